// File: doc/BRIEF.md
# SMBus Host Register Block

This block is the software-facing register file of an SMBus host controller. A processor reaches it through a byte-wide access port with a 4-bit offset. The block holds the transfer setup: command code, target address, two data bytes, a block data byte, the control byte and an auxiliary mode byte. It also holds the status byte. Software clears status flags by writing ones to them. A separate transaction sequencer sets those flags through event inputs.

Writing the control byte with its start bit set makes the block emit a one-cycle launch pulse toward the sequencer. If interrupt enable is 0 in that same write, the launch is held back. Host busy goes high at once, and the launch fires only after software next reads the status byte. The interrupt output is a level. It is computed from the registered state, so it updates in the cycle after any access or event that changes its inputs.

When block-buffer mode is on, accesses to the block data offset go to an external buffer through an index. The block owns that index and wraps it at the buffer depth. The buffer itself is not part of this block.

Top module: `smb_host_regs`

## Requirements
- R1: Registers sit at these offsets: status 0x0, control 0x2, command 0x3, address 0x4, data0 0x5, data1 0x6, block data 0x7, auxiliary 0xD. Any other offset reads 0x00 and ignores writes.
- R2: After reset:
  - status reads 0x00 and irq is 0;
  - op_done_o is 1 and buf_idx_o is 0;
  - auxiliary reads {FORCE_BLK,0}.
- R3: The status bits are: 0 host busy, 1 done, 2 device error, 3 bus error, 4 failed, 5 alert, 6 in use, 7 byte done.
  - A status write clears each of bits 7:1 that is written as 1.
  - A set from seq_evt_set in the same cycle wins over the clear.
  - Software cannot clear bit 0.
- R4: The control bits are: 0 interrupt enable, 1 kill, 4:2 protocol, 5 last byte, 6 start, 7 PEC enable. Bit 6 is never stored (ctl_o[6] is 0). A control read returns only bits 4:0.
- R5: A control write with start=1, interrupt enable=1 and kill=0 raises launch_o for the one cycle after the write and clears op_done_o.
- R6: A control write with start=1, interrupt enable=0 and kill=0 does not launch. It sets host busy and arms a pending launch. The next status read returns the value with busy=1. After that read, busy is 0 and launch_o pulses in the following cycle.
- R7: A control write with kill=1 has these effects:
  - it sets failed (bit 4) and clears host busy;
  - it sets op_done_o and zeroes the index;
  - it drops any pending launch and suppresses launch even when start is also 1.
- R8: irq is 1 exactly when stored interrupt enable is 1 and any of status bits 7:1 is 1. Host busy never raises irq.
- R9: The auxiliary register keeps only bits 1:0 (bit 0 PEC, bit 1 block-buffer mode).
- R10: When block-buffer mode is on:
  - A block data write pulses buf_we_o with the current index, then advances the index, wrapping at BUF_DEPTH.
  - A block data read returns buf_rdata_i and advances the index.
  - If op_done_o is 0 and the advanced index equals data0, the read ends the operation: op_done_o goes to 1, the index goes to 0 and host busy clears.
- R11: When block-buffer mode is off, block data is a plain byte register. Software writes to it, and seq_blk_we loads it from seq_blk. buf_we_o stays 0.
- R12: seq_d0_we and seq_d1_we load data0 and data1 from the sequencer. seq_busy_clr clears host busy, and seq_op_done sets op_done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access valid this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_off | input | OFF_W | Register offset |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, combinational during the access cycle |
| irq | output | 1 | Level interrupt |
| launch_o | output | 1 | One-cycle transaction launch pulse |
| op_done_o | output | 1 | Operation-done flag |
| ctl_o | output | 8 | Stored control byte |
| cmd_o | output | 8 | Command byte |
| addr_o | output | 8 | Target address byte |
| data0_o | output | 8 | Data0 byte |
| data1_o | output | 8 | Data1 byte |
| blkdat_o | output | 8 | Block data byte (non-buffer mode) |
| aux_o | output | 2 | Auxiliary mode bits |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_idx_o | output | $clog2(BUF_DEPTH) | Buffer index |
| buf_wdata_o | output | 8 | Buffer write data |
| buf_rdata_i | input | 8 | Buffer read data at buf_idx_o |
| seq_evt_set | input | 8 | Per-bit status set events |
| seq_busy_clr | input | 1 | Clear host busy |
| seq_op_done | input | 1 | Set operation done |
| seq_d0_we | input | 1 | Load data0 from seq_d0 |
| seq_d0 | input | 8 | Sequencer data0 |
| seq_d1_we | input | 1 | Load data1 from seq_d1 |
| seq_d1 | input | 8 | Sequencer data1 |
| seq_blk_we | input | 1 | Load block data from seq_blk |
| seq_blk | input | 8 | Sequencer block byte |

## Verification
If the pending-launch flag is stuck or lost, it shows on launch_o. The pulse is either missing in the cycle after the status read, or it appears even though kill dropped the pending launch.

If the status state is wrong, it shows at the port one cycle after the event, as a status readback with busy still set or a cleared flag still present. It also shows as irq following busy alone.

If the index logic is off, the fault appears on the first buffer access. buf_idx_o then fails to wrap at the depth, or op_done_o does not rise on the read that reaches the data0 count.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
    localparam int BYTE_W = 8;

    localparam int OFF_STS = 'h0;
    localparam int OFF_CTL = 'h2;
    localparam int OFF_CMD = 'h3;
    localparam int OFF_ADR = 'h4;
    localparam int OFF_D0  = 'h5;
    localparam int OFF_D1  = 'h6;
    localparam int OFF_BLK = 'h7;
    localparam int OFF_AUX = 'hD;

    localparam int STS_BUSY = 0;
    localparam int STS_FAIL = 4;
    localparam int CTL_IEN  = 0;
    localparam int CTL_KILL = 1;
    localparam int CTL_GO   = 6;
    localparam int AUX_BLK  = 1;

    localparam logic [BYTE_W-1:0] CTL_STORE_MASK = 8'hBF;
    localparam logic [BYTE_W-1:0] CTL_READ_MASK  = 8'h1F;

    typedef struct packed {
        logic sts;
        logic ctl;
        logic cmd;
        logic adr;
        logic d0;
        logic d1;
        logic blk;
        logic aux;
    } sel_t;
endpackage

// File: rtl/smb_reg_decode.sv
module smb_reg_decode
    import smb_host_pkg::*;
#(
    parameter int OFF_W = 4
) (
    input  logic             en,
    input  logic             we,
    input  logic [OFF_W-1:0] off,
    output sel_t             wr_sel,
    output sel_t             rd_sel
);
    sel_t hit;

    always_comb begin
        hit     = '0;
        hit.sts = (off == OFF_W'(OFF_STS));
        hit.ctl = (off == OFF_W'(OFF_CTL));
        hit.cmd = (off == OFF_W'(OFF_CMD));
        hit.adr = (off == OFF_W'(OFF_ADR));
        hit.d0  = (off == OFF_W'(OFF_D0));
        hit.d1  = (off == OFF_W'(OFF_D1));
        hit.blk = (off == OFF_W'(OFF_BLK));
        hit.aux = (off == OFF_W'(OFF_AUX));
        wr_sel  = (en && we)  ? hit : '0;
        rd_sel  = (en && !we) ? hit : '0;
    end
endmodule

// File: rtl/smb_status_unit.sv
module smb_status_unit
    import smb_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic [BYTE_W-1:0] sw_wdata,
    input  logic [BYTE_W-1:0] evt_set,
    input  logic              evt_busy_clr,
    input  logic              busy_set,
    input  logic              busy_drop,
    input  logic              kill,
    output logic [BYTE_W-1:0] sts_q
);
    typedef struct packed {
        logic [BYTE_W-1:0] sts;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // flags 7:1: write-one-to-clear, then events set
        if (sw_wr) begin
            st_d.sts[BYTE_W-1:1] = st_d.sts[BYTE_W-1:1] & ~sw_wdata[BYTE_W-1:1];
        end
        st_d.sts[BYTE_W-1:1] = st_d.sts[BYTE_W-1:1] | evt_set[BYTE_W-1:1];
        if (kill) begin
            st_d.sts[STS_FAIL] = 1'b1;
        end
        // host busy: software writes have no effect
        if (evt_set[STS_BUSY]) st_d.sts[STS_BUSY] = 1'b1;
        if (evt_busy_clr)      st_d.sts[STS_BUSY] = 1'b0;
        if (busy_set)          st_d.sts[STS_BUSY] = 1'b1;
        if (busy_drop)         st_d.sts[STS_BUSY] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_q = st_q.sts;
endmodule

// File: rtl/smb_launch_ctrl.sv
module smb_launch_ctrl
    import smb_host_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    parameter int IDX_W     = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              sts_rd,
    input  logic              blk_wr,
    input  logic              blk_rd,
    input  logic              aux_blk,
    input  logic [BYTE_W-1:0] data0,
    input  logic              seq_op_done,
    output logic              launch_o,
    output logic              busy_set_o,
    output logic              busy_drop_o,
    output logic              kill_o,
    output logic              op_done_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BUF_DEPTH - 1);

    typedef struct packed {
        logic             pend;
        logic             op_done;
        logic             launch;
        logic [IDX_W-1:0] idx;
    } st_t;

    st_t  st_d, st_q;
    logic go, kill;
    logic [IDX_W-1:0]  idx_inc;
    logic [BYTE_W-1:0] cnt_next;

    always_comb begin
        go       = ctl_wr && wdata[CTL_GO];
        kill     = ctl_wr && wdata[CTL_KILL];
        idx_inc  = (st_q.idx == IDX_LAST) ? '0 : st_q.idx + 1'b1;
        cnt_next = BYTE_W'(st_q.idx) + 1'b1;

        st_d        = st_q;
        st_d.launch = 1'b0;
        busy_set_o  = 1'b0;
        busy_drop_o = 1'b0;

        if (seq_op_done) st_d.op_done = 1'b1;

        // deferred launch fires on a status read
        if (sts_rd && st_q.pend) begin
            st_d.pend    = 1'b0;
            st_d.launch  = 1'b1;
            st_d.op_done = 1'b0;
            busy_drop_o  = 1'b1;
        end

        if (go) begin
            st_d.idx     = '0;
            st_d.op_done = 1'b1;
            if (wdata[CTL_IEN]) begin
                st_d.launch  = 1'b1;
                st_d.op_done = 1'b0;
                st_d.pend    = 1'b0;
            end else begin
                st_d.pend  = 1'b1;
                busy_set_o = 1'b1;
            end
        end

        if (kill) begin
            st_d.launch  = 1'b0;
            st_d.pend    = 1'b0;
            st_d.op_done = 1'b1;
            st_d.idx     = '0;
            busy_set_o   = 1'b0;
            busy_drop_o  = 1'b1;
        end

        if (aux_blk && blk_wr) begin
            st_d.idx = idx_inc;
        end

        if (aux_blk && blk_rd) begin
            st_d.idx = idx_inc;
            if (!st_q.op_done && (cnt_next == data0)) begin
                st_d.op_done = 1'b1;
                st_d.idx     = '0;
                busy_drop_o  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.op_done <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign launch_o  = st_q.launch;
    assign op_done_o = st_q.op_done;
    assign idx_o     = st_q.idx;
    assign kill_o    = kill;
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_host_pkg::*;
#(
    parameter int OFF_W     = 4,
    parameter int BUF_DEPTH = 32,
    parameter bit FORCE_BLK = 1'b0,
    parameter int IDX_W     = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [OFF_W-1:0]  acc_off,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    output logic              irq,
    output logic              launch_o,
    output logic              op_done_o,
    output logic [7:0]        ctl_o,
    output logic [7:0]        cmd_o,
    output logic [7:0]        addr_o,
    output logic [7:0]        data0_o,
    output logic [7:0]        data1_o,
    output logic [7:0]        blkdat_o,
    output logic [1:0]        aux_o,
    output logic              buf_we_o,
    output logic [IDX_W-1:0]  buf_idx_o,
    output logic [7:0]        buf_wdata_o,
    input  logic [7:0]        buf_rdata_i,
    input  logic [7:0]        seq_evt_set,
    input  logic              seq_busy_clr,
    input  logic              seq_op_done,
    input  logic              seq_d0_we,
    input  logic [7:0]        seq_d0,
    input  logic              seq_d1_we,
    input  logic [7:0]        seq_d1,
    input  logic              seq_blk_we,
    input  logic [7:0]        seq_blk
);
    localparam int AUX_W = 2;

    typedef struct packed {
        logic [BYTE_W-1:0] ctl;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] adr;
        logic [BYTE_W-1:0] d0;
        logic [BYTE_W-1:0] d1;
        logic [BYTE_W-1:0] blk;
        logic [AUX_W-1:0]  aux;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    sel_t wr_sel, rd_sel;
    logic [BYTE_W-1:0] sts_q;
    logic busy_set, busy_drop, kill;
    logic blk_mode;

    smb_reg_decode #(.OFF_W(OFF_W)) u_dec (
        .en     (acc_en),
        .we     (acc_we),
        .off    (acc_off),
        .wr_sel (wr_sel),
        .rd_sel (rd_sel)
    );

    assign blk_mode = cfg_q.aux[AUX_BLK];

    smb_launch_ctrl #(.BUF_DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_launch (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (wr_sel.ctl),
        .wdata       (acc_wdata),
        .sts_rd      (rd_sel.sts),
        .blk_wr      (wr_sel.blk),
        .blk_rd      (rd_sel.blk),
        .aux_blk     (blk_mode),
        .data0       (cfg_q.d0),
        .seq_op_done (seq_op_done),
        .launch_o    (launch_o),
        .busy_set_o  (busy_set),
        .busy_drop_o (busy_drop),
        .kill_o      (kill),
        .op_done_o   (op_done_o),
        .idx_o       (buf_idx_o)
    );

    smb_status_unit u_sts (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_wr        (wr_sel.sts),
        .sw_wdata     (acc_wdata),
        .evt_set      (seq_evt_set),
        .evt_busy_clr (seq_busy_clr),
        .busy_set     (busy_set),
        .busy_drop    (busy_drop),
        .kill         (kill),
        .sts_q        (sts_q)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (wr_sel.ctl) cfg_d.ctl = acc_wdata & CTL_STORE_MASK;
        if (wr_sel.cmd) cfg_d.cmd = acc_wdata;
        if (wr_sel.adr) cfg_d.adr = acc_wdata;
        if (seq_d0_we)  cfg_d.d0  = seq_d0;
        if (wr_sel.d0)  cfg_d.d0  = acc_wdata;
        if (seq_d1_we)  cfg_d.d1  = seq_d1;
        if (wr_sel.d1)  cfg_d.d1  = acc_wdata;
        if (seq_blk_we) cfg_d.blk = seq_blk;
        if (wr_sel.blk && !blk_mode) cfg_d.blk = acc_wdata;
        if (wr_sel.aux) cfg_d.aux = acc_wdata[AUX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q              <= '0;
            cfg_q.aux[AUX_BLK] <= FORCE_BLK;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        acc_rdata = '0;
        unique case (1'b1)
            rd_sel.sts: acc_rdata = sts_q;
            rd_sel.ctl: acc_rdata = cfg_q.ctl & CTL_READ_MASK;
            rd_sel.cmd: acc_rdata = cfg_q.cmd;
            rd_sel.adr: acc_rdata = cfg_q.adr;
            rd_sel.d0:  acc_rdata = cfg_q.d0;
            rd_sel.d1:  acc_rdata = cfg_q.d1;
            rd_sel.blk: acc_rdata = blk_mode ? buf_rdata_i : cfg_q.blk;
            rd_sel.aux: acc_rdata = {{(BYTE_W-AUX_W){1'b0}}, cfg_q.aux};
            default:    acc_rdata = '0;
        endcase
    end

    assign irq         = cfg_q.ctl[CTL_IEN] && (|sts_q[BYTE_W-1:1]);
    assign buf_we_o    = wr_sel.blk && blk_mode;
    assign buf_wdata_o = acc_wdata;
    assign ctl_o       = cfg_q.ctl;
    assign cmd_o       = cfg_q.cmd;
    assign addr_o      = cfg_q.adr;
    assign data0_o     = cfg_q.d0;
    assign data1_o     = cfg_q.d1;
    assign blkdat_o    = cfg_q.blk;
    assign aux_o       = cfg_q.aux;
endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk #(
    parameter int OFF_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_en,
    input logic             acc_we,
    input logic [OFF_W-1:0] acc_off,
    input logic [7:0]       acc_wdata,
    input logic [7:0]       acc_rdata,
    input logic [7:0]       sts,
    input logic [7:0]       ctl,
    input logic             launch,
    input logic             op_done,
    input logic             seq_busy_clr
);
    logic known_off, ctl_wr, sts_wr;

    assign known_off = (acc_off == OFF_W'(0)) || (acc_off == OFF_W'(2)) ||
                       (acc_off == OFF_W'(3)) || (acc_off == OFF_W'(4)) ||
                       (acc_off == OFF_W'(5)) || (acc_off == OFF_W'(6)) ||
                       (acc_off == OFF_W'(7)) || (acc_off == OFF_W'(13));
    assign ctl_wr = acc_en && acc_we && (acc_off == OFF_W'(2));
    assign sts_wr = acc_en && acc_we && (acc_off == OFF_W'(0));

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we && !known_off) |-> (acc_rdata == 8'h00)); // R1
    AST_BUSY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && acc_wdata[0] && sts[0] && !seq_busy_clr) |=> sts[0]); // R3
    AST_START_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[6]); // R4
    AST_IMM_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && acc_wdata[6] && acc_wdata[0] && !acc_wdata[1]) |=> (launch && !op_done)); // R5
    AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && acc_wdata[6] && !acc_wdata[0] && !acc_wdata[1]) |=> (sts[0] && !launch)); // R6
    AST_KILL_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && acc_wdata[1]) |=> (sts[4] && !sts[0] && op_done && !launch)); // R7
endmodule

bind smb_host_regs smb_host_regs_chk #(.OFF_W(OFF_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_en       (acc_en),
    .acc_we       (acc_we),
    .acc_off      (acc_off),
    .acc_wdata    (acc_wdata),
    .acc_rdata    (acc_rdata),
    .sts          (sts_q),
    .ctl          (ctl_o),
    .launch       (launch_o),
    .op_done      (op_done_o),
    .seq_busy_clr (seq_busy_clr)
);

// File: tb/sim_smb_host_regs.sv
module sim_smb_host_regs;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;
    localparam int IW         = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_en = 1'b0, acc_we = 1'b0;
    logic [3:0] acc_off = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic irq, launch_o, op_done_o, buf_we_o;
    logic [7:0] ctl_o, cmd_o, addr_o, data0_o, data1_o, blkdat_o, buf_wdata_o, buf_rdata_i;
    logic [1:0] aux_o;
    logic [IW-1:0] buf_idx_o;
    logic [7:0] seq_evt_set = '0;
    logic seq_busy_clr = 1'b0, seq_op_done = 1'b0;
    logic seq_d0_we = 1'b0, seq_d1_we = 1'b0, seq_blk_we = 1'b0;
    logic [7:0] seq_d0 = '0, seq_d1 = '0, seq_blk = '0;

    int checks = 0;
    int errors = 0;
    logic last_we;
    logic [IW-1:0] last_idx;
    logic [7:0] v;

    assign buf_rdata_i = 8'h50 + 8'(buf_idx_o);

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_host_regs #(.OFF_W(4), .BUF_DEPTH(DEPTH), .FORCE_BLK(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
        .acc_off(acc_off), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .irq(irq), .launch_o(launch_o), .op_done_o(op_done_o),
        .ctl_o(ctl_o), .cmd_o(cmd_o), .addr_o(addr_o), .data0_o(data0_o),
        .data1_o(data1_o), .blkdat_o(blkdat_o), .aux_o(aux_o),
        .buf_we_o(buf_we_o), .buf_idx_o(buf_idx_o), .buf_wdata_o(buf_wdata_o),
        .buf_rdata_i(buf_rdata_i), .seq_evt_set(seq_evt_set),
        .seq_busy_clr(seq_busy_clr), .seq_op_done(seq_op_done),
        .seq_d0_we(seq_d0_we), .seq_d0(seq_d0), .seq_d1_we(seq_d1_we),
        .seq_d1(seq_d1), .seq_blk_we(seq_blk_we), .seq_blk(seq_blk)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] o, input logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_off = o; acc_wdata = d;
        #1 last_we = buf_we_o; last_idx = buf_idx_o;
        @(posedge clk);
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] o, output logic [7:0] r);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_off = o;
        #1 r = acc_rdata;
        @(posedge clk);
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic seq_pulse(input logic [7:0] ev, input logic bclr, input logic opd);
        @(negedge clk);
        seq_evt_set = ev; seq_busy_clr = bclr; seq_op_done = opd;
        @(posedge clk);
        @(negedge clk);
        seq_evt_set = '0; seq_busy_clr = 1'b0; seq_op_done = 1'b0;
    endtask

    task automatic seq_load(input logic d0we, input logic [7:0] d0, input logic d1we,
                            input logic [7:0] d1, input logic bwe, input logic [7:0] b);
        @(negedge clk);
        seq_d0_we = d0we; seq_d0 = d0; seq_d1_we = d1we; seq_d1 = d1;
        seq_blk_we = bwe; seq_blk = b;
        @(posedge clk);
        @(negedge clk);
        seq_d0_we = 1'b0; seq_d1_we = 1'b0; seq_blk_we = 1'b0;
    endtask

    task automatic t_reset;
        rd(4'h0, v);  chk("R2 status", v, 8'h00);
        rd(4'hD, v);  chk("R2 aux", v, 8'h00);
        chk("R2 op_done", op_done_o, 1'b1);
        chk("R2 idx", buf_idx_o, 0);
        chk("R2 irq", irq, 1'b0);
    endtask

    task automatic t_regs;
        wr(4'h3, 8'hC3); rd(4'h3, v); chk("R1 cmd", v, 8'hC3);
        wr(4'h4, 8'hA5); rd(4'h4, v); chk("R1 addr", v, 8'hA5);
        wr(4'h5, 8'h11); rd(4'h5, v); chk("R1 data0", v, 8'h11);
        wr(4'h6, 8'h22); rd(4'h6, v); chk("R1 data1", v, 8'h22);
        wr(4'h1, 8'hFF); rd(4'h1, v); chk("R1 reserved 0x1", v, 8'h00);
        rd(4'hE, v); chk("R1 reserved 0xE", v, 8'h00);
        chk("R1 reserved write no effect", {cmd_o, addr_o}, 16'hC3A5);
        wr(4'hD, 8'hFC); rd(4'hD, v); chk("R9 aux mask", v, 8'h00);
        wr(4'hD, 8'hFD); rd(4'hD, v); chk("R9 aux keep", v, 8'h01);
        wr(4'hD, 8'h00);
        wr(4'h2, 8'hBC); rd(4'h2, v); chk("R4 ctl read mask", v, 8'h1C);
        chk("R4 ctl stored", ctl_o, 8'hBC);
        wr(4'h2, 8'h00);
    endtask

    task automatic t_immediate;
        wr(4'h2, 8'h41);
        chk("R5 launch", launch_o, 1'b1);
        chk("R5 op_done low", op_done_o, 1'b0);
        chk("R4 start not stored", ctl_o, 8'h01);
        @(negedge clk);
        chk("R5 single pulse", launch_o, 1'b0);
        seq_pulse(8'h00, 1'b0, 1'b1);
        chk("R12 op_done set", op_done_o, 1'b1);
    endtask

    task automatic t_defer;
        wr(4'h2, 8'h40);
        chk("R6 no launch at write", launch_o, 1'b0);
        rd(4'h0, v);
        chk("R6 read shows busy", v, 8'h01);
        chk("R6 launch after read", launch_o, 1'b1);
        chk("R6 op_done low", op_done_o, 1'b0);
        rd(4'h0, v);
        chk("R6 busy cleared", v, 8'h00);
        seq_pulse(8'h00, 1'b0, 1'b1);
    endtask

    task automatic t_w1c;
        wr(4'h2, 8'h01);
        seq_pulse(8'hFE, 1'b0, 1'b0);
        chk("R8 irq on flags", irq, 1'b1);
        rd(4'h0, v); chk("R3 flags set", v, 8'hFE);
        wr(4'h0, 8'h02); rd(4'h0, v); chk("R3 w1c one bit", v, 8'hFC);
        seq_pulse(8'h01, 1'b0, 1'b0);
        rd(4'h0, v); chk("R3 busy from seq", v, 8'hFD);
        wr(4'h0, 8'hFF); rd(4'h0, v); chk("R3 busy not sw clearable", v, 8'h01);
        chk("R8 busy ignored", irq, 1'b0);
        seq_pulse(8'h00, 1'b1, 1'b0);
        rd(4'h0, v); chk("R12 busy clr", v, 8'h00);
    endtask

    task automatic t_kill;
        wr(4'h2, 8'h40);
        wr(4'h2, 8'h02);
        rd(4'h0, v);
        chk("R7 failed set busy clr", v, 8'h10);
        chk("R7 pending dropped", launch_o, 1'b0);
        chk("R7 op_done", op_done_o, 1'b1);
        chk("R8 irq gated by enable", irq, 1'b0);
        wr(4'h2, 8'h43);
        chk("R7 kill suppresses start", launch_o, 1'b0);
        wr(4'h2, 8'h01);
        chk("R8 irq with enable", irq, 1'b1);
    endtask

    task automatic t_block;
        wr(4'hD, 8'h02);
        wr(4'h7, 8'hA1);
        chk("R10 buf we", last_we, 1'b1);
        chk("R10 buf idx at write", last_idx, 0);
        chk("R10 idx advance", buf_idx_o, 1);
        for (int i = 0; i < DEPTH - 1; i++) wr(4'h7, 8'(i));
        chk("R10 idx wrap", buf_idx_o, 0);
        wr(4'h5, 8'h03);
        wr(4'h2, 8'h41);
        seq_pulse(8'h01, 1'b0, 1'b0);
        rd(4'h7, v); chk("R10 read 0", v, 8'h50);
        rd(4'h7, v); chk("R10 read 1", v, 8'h51);
        chk("R10 not done yet", op_done_o, 1'b0);
        rd(4'h7, v); chk("R10 read 2", v, 8'h52);
        chk("R10 done at count", op_done_o, 1'b1);
        chk("R10 idx reset", buf_idx_o, 0);
        rd(4'h0, v); chk("R10 busy cleared", v, 8'h10);
    endtask

    task automatic t_plain;
        wr(4'hD, 8'h00);
        wr(4'h7, 8'h5A);
        chk("R11 no buf we", last_we, 1'b0);
        rd(4'h7, v); chk("R11 plain blk", v, 8'h5A);
        seq_load(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h77);
        rd(4'h7, v); chk("R11 seq blk", v, 8'h77);
        seq_load(1'b1, 8'h12, 1'b1, 8'h34, 1'b0, 8'h00);
        rd(4'h5, v); chk("R12 seq d0", v, 8'h12);
        rd(4'h6, v); chk("R12 seq d1", v, 8'h34);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regs;
        t_immediate;
        t_defer;
        t_w1c;
        t_kill;
        t_block;
        t_plain;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule